// File: doc/BRIEF.md
# Flow-Control Pause Frame Detector

This block watches the byte stream that a MAC receiver delivers and picks out the flow-control pause frames in it. Bytes arrive one per beat with start and end markers. The end beat also carries a check-sequence verdict. A frame counts as a pause request when four things hold: its destination is either the station's own programmed address or the reserved flow-control multicast address, its type field marks it as a MAC control frame, its opcode selects pause, and it ends with no error of any kind.

The block holds every decision until the end beat arrives. One cycle after that beat it emits single-cycle strobes. An interrupt strobe and a statistics increment fire for every valid pause frame, whatever the duplex mode. A load strobe fires only when the MAC runs full duplex. The 16-bit pause quantum from the frame is presented alongside the strobes. The input side is a valid/ready stream. The detector never applies back-pressure: `rx_ready` stays high, so every beat with `rx_valid` high is consumed in that cycle. The upstream source may still insert idle cycles wherever it likes.

Top module: `pause_frame_detector`

## Requirements
- R1: `rx_ready` is high in every cycle after reset, and every beat with `rx_valid` high is consumed.
- R2: A destination address equal to `station_addr` is accepted. Byte 0 of the frame is compared with `station_addr[47:40]` and byte 5 with `station_addr[7:0]`.
- R3: A destination address equal to 01-80-C2-00-00-01 (byte 0 = 0x01) is accepted whatever the value of `station_addr`.
- R4: Byte 12 must be 0x88, byte 13 must be 0x08, byte 14 must be 0x00 and byte 15 must be 0x01. Any other value in any of these bytes rejects the frame.
- R5: On a valid frame, `pause_time` shows {byte 16, byte 17} (byte 16 is the high byte) in the same cycle as the strobes. At all other times it keeps the value it last showed.
- R6: A frame whose end beat has `rx_fcs_ok` low, or that has `rx_err` high on any of its beats, produces no strobe.
- R7: Every valid frame raises `pause_irq` and `stat_inc` for exactly one cycle, in full-duplex and half-duplex mode alike.
- R8: `pause_load` rises with `pause_irq` only if `full_duplex` was high on the end beat. Otherwise it stays low.
- R9: The strobes appear in the cycle right after the end beat and last one cycle.
- R10: A frame with fewer than 18 bytes is never accepted. Bytes beyond byte 17 (padding) do not affect the decision.
- R11: A start beat while a frame is still open discards the open frame and begins a new one. Beats that arrive outside a frame are ignored.
- R12: After reset all strobes are low and `pause_time` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Byte beat valid |
| rx_ready | output | 1 | Always high; beat accepted |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | Beat is the first byte of a frame |
| rx_eof | input | 1 | Beat is the last byte of a frame |
| rx_fcs_ok | input | 1 | Check sequence good, sampled on the end beat |
| rx_err | input | 1 | Receive error on this beat |
| station_addr | input | 48 | Programmed station address, first byte in bits 47:40 |
| full_duplex | input | 1 | MAC is in full-duplex mode |
| pause_irq | output | 1 | Valid pause frame seen (one-cycle pulse) |
| pause_load | output | 1 | Load pause timer request, full duplex only |
| pause_time | output | 16 | Pause quantum from the last valid frame |
| stat_inc | output | 1 | Pause-frame statistic increment pulse |

## Verification
Two things can fall in the same cycle: the final byte's evaluation and the verdict on the whole frame. Both are decided on the end beat, where the last header or time byte, a receive error and the check-sequence status all arrive together. The bench provokes this case with frames that end exactly at byte 18 and carry an error or a bad check sequence on that beat. It also provokes a fresh start marker on a beat while a frame is still open, so that the restart and the first address compare happen together. In each case the bench judges the outcome by the strobes one cycle later and by `pause_time`, which must keep its previous value.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = 8 * ADDR_BYTES;
  localparam logic [ADDR_W-1:0] MC_ADDR = 48'h0180_C200_0001;
  localparam logic [15:0] CTRL_TYPE = 16'h8808;
  localparam logic [15:0] PAUSE_OPC = 16'h0001;
  localparam int TYPE_POS  = 12;
  localparam int OPC_POS   = 14;
  localparam int TIME_POS  = 16;
  localparam int FRAME_MIN = 18;
  localparam int IDX_W     = $clog2(FRAME_MIN) + 1;
  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};
endpackage

// File: rtl/pfd_match.sv
module pfd_match
  import pfd_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  input  logic [7:0]        data,
  input  logic [ADDR_W-1:0] station_addr,
  output logic              prog_hit,
  output logic              mc_hit,
  output logic              hdr_hit
);
  logic [7:0] prog_exp [ADDR_BYTES];
  logic [7:0] mc_exp   [ADDR_BYTES];

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr
    assign prog_exp[g] = station_addr[8*(ADDR_BYTES-1-g) +: 8];
    assign mc_exp[g]   = MC_ADDR[8*(ADDR_BYTES-1-g) +: 8];
  end

  always_comb begin
    prog_hit = 1'b1;
    mc_hit   = 1'b1;
    for (int k = 0; k < ADDR_BYTES; k++) begin
      if (idx == IDX_W'(k)) begin
        prog_hit = (data == prog_exp[k]);
        mc_hit   = (data == mc_exp[k]);
      end
    end
  end

  always_comb begin
    hdr_hit = 1'b1;
    if (idx == IDX_W'(TYPE_POS))     hdr_hit = (data == CTRL_TYPE[15:8]);
    if (idx == IDX_W'(TYPE_POS + 1)) hdr_hit = (data == CTRL_TYPE[7:0]);
    if (idx == IDX_W'(OPC_POS))      hdr_hit = (data == PAUSE_OPC[15:8]);
    if (idx == IDX_W'(OPC_POS + 1))  hdr_hit = (data == PAUSE_OPC[7:0]);
  end
endmodule

// File: rtl/pfd_capture.sv
module pfd_capture
  import pfd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       data,
  output logic [15:0]      time_word
);
  logic [7:0] hi_q, lo_q;
  logic       at_hi, at_lo;

  assign at_hi = (idx == IDX_W'(TIME_POS));
  assign at_lo = (idx == IDX_W'(TIME_POS + 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (take) begin
      if (at_hi) hi_q <= data;
      if (at_lo) lo_q <= data;
    end
  end

  assign time_word = {at_hi ? data : hi_q, at_lo ? data : lo_q};
endmodule

// File: rtl/pause_frame_detector.sv
module pause_frame_detector
  import pfd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic              rx_fcs_ok,
  input  logic              rx_err,
  input  logic [ADDR_W-1:0] station_addr,
  input  logic              full_duplex,
  output logic              pause_irq,
  output logic              pause_load,
  output logic [15:0]       pause_time,
  output logic              stat_inc
);
  logic             in_frame_q;
  logic [IDX_W-1:0] idx_q, idx_cur;
  logic             prog_q, mc_q, hdr_q, err_q;
  logic             prog_n, mc_n, hdr_n, err_n;
  logic             prog_hit, mc_hit, hdr_hit;
  logic             take, verdict;
  logic [15:0]      time_word;

  assign rx_ready = 1'b1;
  assign take     = rx_valid && (rx_sof || in_frame_q);
  assign idx_cur  = rx_sof ? '0 : idx_q;

  pfd_match u_match (
    .idx(idx_cur), .data(rx_data), .station_addr(station_addr),
    .prog_hit(prog_hit), .mc_hit(mc_hit), .hdr_hit(hdr_hit)
  );

  pfd_capture u_cap (
    .clk(clk), .rst_n(rst_n), .take(take), .idx(idx_cur),
    .data(rx_data), .time_word(time_word)
  );

  // running verdicts including the current beat
  assign prog_n = (rx_sof | prog_q) & prog_hit;
  assign mc_n   = (rx_sof | mc_q) & mc_hit;
  assign hdr_n  = (rx_sof | hdr_q) & hdr_hit;
  assign err_n  = (~rx_sof & err_q) | rx_err;
  assign verdict = take && rx_eof && rx_fcs_ok && !err_n && hdr_n &&
                   (prog_n || mc_n) && (idx_cur >= IDX_W'(FRAME_MIN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      idx_q      <= '0;
      prog_q     <= 1'b0;
      mc_q       <= 1'b0;
      hdr_q      <= 1'b0;
      err_q      <= 1'b0;
    end else if (take) begin
      in_frame_q <= !rx_eof;
      idx_q      <= (idx_cur == IDX_MAX) ? IDX_MAX : idx_cur + 1'b1;
      prog_q     <= prog_n;
      mc_q       <= mc_n;
      hdr_q      <= hdr_n;
      err_q      <= err_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pause_irq  <= 1'b0;
      pause_load <= 1'b0;
      stat_inc   <= 1'b0;
      pause_time <= '0;
    end else begin
      pause_irq  <= verdict;
      stat_inc   <= verdict;
      pause_load <= verdict && full_duplex;
      if (verdict) pause_time <= time_word;
    end
  end
endmodule

// File: rtl/pfd_checker.sv
module pfd_checker
  import pfd_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        rx_valid,
  input logic        rx_ready,
  input logic        rx_eof,
  input logic        rx_fcs_ok,
  input logic        rx_err,
  input logic        full_duplex,
  input logic        pause_irq,
  input logic        pause_load,
  input logic [15:0] pause_time,
  input logic        stat_inc
);
  a_r1_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready);
  a_r7_stat_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
    stat_inc == pause_irq);
  a_r8_load_needs_fd: assert property (@(posedge clk) disable iff (!rst_n)
    pause_load |-> (pause_irq && $past(full_duplex)));
  a_r6_end_beat_clean: assert property (@(posedge clk) disable iff (!rst_n)
    pause_irq |-> $past(rx_valid && rx_eof && rx_fcs_ok && !rx_err));
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pause_irq |=> !pause_irq);
  a_r5_time_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !pause_irq |-> $stable(pause_time));
endmodule

bind pause_frame_detector pfd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_eof(rx_eof), .rx_fcs_ok(rx_fcs_ok), .rx_err(rx_err),
  .full_duplex(full_duplex), .pause_irq(pause_irq), .pause_load(pause_load),
  .pause_time(pause_time), .stat_inc(stat_inc)
);

// File: tb/sim_pause_frame_detector.sv
module sim_pause_frame_detector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic        rx_fcs_ok = 1'b0, rx_err = 1'b0, full_duplex = 1'b1;
  logic [7:0]  rx_data = '0;
  logic [47:0] station_addr = 48'h02AB_CD12_3456;
  logic        rx_ready, pause_irq, pause_load, stat_inc;
  logic [15:0] pause_time;

  int unsigned n_chk = 0, n_bad = 0;
  bit          done = 0;
  logic [7:0]  fr [64];
  logic [15:0] last_time = '0;

  always #10 clk = ~clk;

  pause_frame_detector u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_fcs_ok(rx_fcs_ok),
    .rx_err(rx_err), .station_addr(station_addr), .full_duplex(full_duplex),
    .pause_irq(pause_irq), .pause_load(pause_load), .pause_time(pause_time),
    .stat_inc(stat_inc)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_good(int len, bit fcs, int err_pos);
    bit da_p = 1, da_m = 1;
    logic [47:0] mc = 48'h0180_C200_0001;
    if (len < 18 || !fcs || (err_pos >= 0 && err_pos < len)) return 0;
    for (int i = 0; i < 6; i++) begin
      if (fr[i] != station_addr[8*(5-i) +: 8]) da_p = 0;
      if (fr[i] != mc[8*(5-i) +: 8]) da_m = 0;
    end
    return (da_p || da_m) && fr[12] == 8'h88 && fr[13] == 8'h08 &&
           fr[14] == 8'h00 && fr[15] == 8'h01;
  endfunction

  task automatic build(int da_kind);
    logic [47:0] mc = 48'h0180_C200_0001;
    for (int i = 0; i < 64; i++) fr[i] = 8'($urandom);
    for (int i = 0; i < 6; i++)
      if (da_kind == 0) fr[i] = station_addr[8*(5-i) +: 8];
      else if (da_kind == 1) fr[i] = mc[8*(5-i) +: 8];
    fr[12] = 8'h88; fr[13] = 8'h08; fr[14] = 8'h00; fr[15] = 8'h01;
  endtask

  task automatic drive(int len, bit fcs, int err_pos, bit with_eof);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = fr[i]; rx_sof = (i == 0);
      rx_eof = with_eof && (i == len - 1);
      rx_err = (i == err_pos);
      rx_fcs_ok = rx_eof ? fcs : 1'($urandom);
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_err = 0;
  endtask

  // send a frame and judge it one cycle after its end beat (R9)
  task automatic frame(string tag, int len, bit fcs, int err_pos);
    bit g = exp_good(len, fcs, err_pos);
    logic [15:0] t = g ? {fr[16], fr[17]} : last_time;
    drive(len, fcs, err_pos, 1);
    chk({tag, " R7 irq"}, pause_irq, g);
    chk({tag, " R7 stat"}, stat_inc, g);
    chk({tag, " R8 load"}, pause_load, g && full_duplex);
    chk({tag, " R5 time"}, pause_time, t);
    chk({tag, " R1 ready"}, rx_ready, 1);
    last_time = t;
    @(negedge clk);
    chk({tag, " R9 pulse ends"}, pause_irq | pause_load | stat_inc, 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R12 irq", pause_irq, 0); chk("R12 load", pause_load, 0);
    chk("R12 stat", stat_inc, 0); chk("R12 time", pause_time, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready", rx_ready, 1);

    build(0); fr[16] = 8'hA5; fr[17] = 8'h3C; frame("R2 prog", 18, 1, -1);
    build(1); frame("R3 mc", 18, 1, -1);
    build(1); frame("R10 len17", 17, 1, -1);
    build(0); frame("R10 padded", 60, 1, -1);
    build(0); fr[13] = 8'h09; frame("R4 type", 20, 1, -1);
    build(1); fr[15] = 8'h02; frame("R4 opcode", 20, 1, -1);
    build(2); fr[0] = 8'h55; frame("R2 R3 other da", 20, 1, -1);
    build(0); frame("R6 fcs bad at end", 18, 0, -1);
    build(1); frame("R6 err on end beat", 18, 1, 17);
    build(0); frame("R6 err early", 30, 1, 3);
    full_duplex = 0;
    build(1); frame("R7 R8 half duplex", 22, 1, -1);
    full_duplex = 1;
    // R11: open frame abandoned by a fresh start
    build(0); drive(9, 1, -1, 0);
    build(1); frame("R11 restart", 18, 1, -1);
    // R11: stray beats outside a frame
    build(0);
    for (int i = 0; i < 18; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = fr[i]; rx_sof = 0; rx_eof = (i == 17);
      rx_fcs_ok = 1;
    end
    @(negedge clk); rx_valid = 0; rx_eof = 0;
    chk("R11 stray irq", pause_irq, 0);
    chk("R11 stray time", pause_time, last_time);

    for (int n = 0; n < 300; n++) begin
      int len = 8 + int'($urandom_range(0, 40));
      int ep = ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 47)) : -1;
      bit fcs = ($urandom_range(0, 9) != 0);
      build(int'($urandom_range(0, 2)));
      if ($urandom_range(0, 3) == 0) fr[$urandom_range(12, 15)] ^= 8'h10;
      if ($urandom_range(0, 7) == 0) fr[$urandom_range(0, 5)] ^= 8'h01;
      full_duplex = 1'($urandom);
      frame("R7 random", len, fcs, ep);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule